// File: doc/BRIEF.md
# Shared Cell Buffer Manager with Multicast Release

This block keeps track of a pool of fixed-size cell slots in a cell memory. A slot takes fourteen 32-bit words: one control word, one cell header word and twelve payload words. Slots that are not in use sit on a singly linked free list. The link word of a slot is read only while that slot is free. A requester asks for a slot and receives its index one cycle later. It then places that index on one or more per-destination transmit queues. The first enqueue records the cell's metadata: a multicast count, a 2-bit origin and a 16-bit virtual-circuit index.

Each transmit queue is a linked FIFO that has its own head, tail and occupancy. A dequeue pops the head of the chosen queue and reports the cell's metadata and the word address of its slot. The dequeue also lowers the cell's multicast count by one. The dequeue that brings the count to zero returns the slot to the head of the free list, whichever queue it came from. A slot can be released and a new one granted in the same cycle. In that case the grant comes from the old list head and the released slot becomes the new head, so no slot is handed out twice.

Top module: `cell_buf_mgr`

## Requirements
- R1: After reset every slot is free, `free_slots` equals NUM_SLOTS, and successive allocations with no releases return indices 0, 1, 2, ... in ascending order.
- R2: An allocation request made while slots are free gives `alloc_gnt` high with `alloc_ptr` one cycle later, and `free_slots` drops by one.
- R3: An allocation request made while no slot is free gives `alloc_gnt` low and sets `pool_exhausted`, which stays high until reset. The list head is kept, so a slot released later is granted correctly.
- R4: Accepted enqueues to one queue come back from dequeues of that queue in the same order, with `deq_valid` high.
- R5: Every dequeue request is answered one cycle later with `deq_ack` high. If the queue is empty, `deq_valid` is low and nothing changes.
- R6: The multicast count is loaded from `enq_mcast` on the first accepted enqueue of a slot, and the values on later enqueues are ignored. Each successful dequeue of the slot lowers the count. Only the dequeue that takes the count to zero raises `deq_released` and frees the slot.
- R7: A released slot goes to the head of the free list, so the next allocation returns the slot released most recently.
- R8: When an allocation and a release happen in the same cycle, the grant is the old list head and the released slot becomes the next slot granted. `free_slots` does not change, and no slot is granted twice.
- R9: An enqueue with `enq_mcast` equal to zero is rejected: `enq_err` pulses one cycle later and no queue changes.
- R10: An enqueue is also rejected with `enq_err` in three cases: the slot is not allocated, the slot is already on that queue, or the slot is being released in that cycle.
- R11: A dequeue returns the origin and the circuit index stored at the first enqueue. Origin encoding: 00 receive port A, 01 receive port B, 10 transmit AAL2 path, 11 transmit CPU path.
- R12: `deq_base` equals the slot index times 14, which is the word address of the slot's control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Request one free slot |
| alloc_gnt | output | 1 | Grant, one cycle after the request |
| alloc_ptr | output | $clog2(NUM_SLOTS) | Granted slot index |
| pool_exhausted | output | 1 | Sticky flag: a request found no free slot |
| free_slots | output | $clog2(NUM_SLOTS+1) | Number of free slots |
| enq_valid | input | 1 | Enqueue strobe |
| enq_ptr | input | $clog2(NUM_SLOTS) | Slot to enqueue |
| enq_qid | input | $clog2(NUM_QUEUES) | Destination queue |
| enq_mcast | input | MC_W | Multicast count (used on first enqueue) |
| enq_src | input | 2 | Cell origin code |
| enq_vc | input | VC_W | Virtual-circuit index |
| enq_err | output | 1 | Enqueue rejected, one cycle later |
| deq_req | input | 1 | Dequeue / transmit-done strobe |
| deq_qid | input | $clog2(NUM_QUEUES) | Queue to pop |
| deq_ack | output | 1 | Dequeue answered |
| deq_valid | output | 1 | A cell was popped |
| deq_ptr | output | $clog2(NUM_SLOTS) | Popped slot index |
| deq_base | output | $clog2(NUM_SLOTS*14) | Word address of the popped slot |
| deq_src | output | 2 | Stored origin code |
| deq_vc | output | VC_W | Stored circuit index |
| deq_released | output | 1 | This pop freed the slot |

## Verification
The embedded assertions check the following on every cycle:
- The free-slot count plus the number of allocated slots always equals the pool size.
- No grant ever names a slot that is already allocated.
- Each queue's occupancy matches its membership bits.
- No multicast count is decremented below zero.
- The exhaustion flag stays set once raised.

The ordering behaviours can only be shown by the bench scenarios. These are the ascending order after reset, the LIFO reuse of released slots, the FIFO order within a queue, and the old-head grant during a same-cycle release. The bench also shows which queue's dequeue finally frees a multicast cell and that the stored metadata and slot addresses come back correctly.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned CTRL_WORDS    = 1;
  localparam int unsigned HDR_WORDS     = 1;
  localparam int unsigned PAYLOAD_WORDS = 12;
  localparam int unsigned SLOT_WORDS    = CTRL_WORDS + HDR_WORDS + PAYLOAD_WORDS;

  typedef enum logic [1:0] {
    SRC_RX_A    = 2'b00,
    SRC_RX_B    = 2'b01,
    SRC_TX_AAL2 = 2'b10,
    SRC_TX_CPU  = 2'b11
  } cell_src_e;

  // Word address of a slot's control word within the cell memory.
  function automatic int unsigned slot_word_base(input int unsigned idx);
    return idx * SLOT_WORDS;
  endfunction

  // Multicast count after one transmission; zero means the slot is free.
  function automatic int unsigned mc_after_send(input int unsigned mc);
    return (mc == 0) ? 0 : mc - 1;
  endfunction
endpackage

// File: rtl/cbm_free_list.sv
module cbm_free_list #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [PW-1:0] give_ptr,
  output logic          take_ok,
  output logic [PW-1:0] head_ptr,
  output logic [CW-1:0] avail
);
  logic [PW-1:0] link_q [SLOTS];
  logic [PW-1:0] head_q;
  logic [PW-1:0] head_after_take;
  logic [CW-1:0] cnt_q;

  assign take_ok         = take && (cnt_q != '0);
  assign head_after_take = take_ok ? link_q[head_q] : head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= CW'(SLOTS);
      for (int i = 0; i < SLOTS; i++) link_q[i] <= PW'((i + 1) % SLOTS);
    end else begin
      head_q <= give ? give_ptr : head_after_take;
      if (give) link_q[give_ptr] <= head_after_take;
      cnt_q <= cnt_q + CW'(give) - CW'(take_ok);
    end
  end

  assign head_ptr = head_q;
  assign avail    = cnt_q;

  AST_FL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SLOTS)); // R1
  AST_EMPTY_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == '0 && !give) |=> (head_q == $past(head_q) && cnt_q == '0)); // R3
  AST_GIVE_IS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (give && take) |=> (head_q == $past(give_ptr))); // R8
endmodule

// File: rtl/cbm_tx_queues.sv
module cbm_tx_queues #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned QUEUES = 4,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned QW = $clog2(QUEUES),
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_do,
  input  logic [QW-1:0] enq_q,
  input  logic [PW-1:0] enq_ptr,
  input  logic          deq_req,
  input  logic [QW-1:0] deq_q,
  output logic          deq_hit,
  output logic [PW-1:0] deq_ptr,
  output logic          enq_dup
);
  logic [QUEUES-1:0] nonempty;
  logic [PW-1:0]     head_v   [QUEUES];
  logic [SLOTS-1:0]  member_v [QUEUES];

  for (genvar g = 0; g < QUEUES; g++) begin : g_q
    logic [PW-1:0]    head_q, tail_q;
    logic [CW-1:0]    cnt_q;
    logic [PW-1:0]    nxt_q [SLOTS];
    logic [SLOTS-1:0] mem_q;
    logic             push, pop;
    logic [SLOTS-1:0] set_bit, clr_bit;

    assign push    = enq_do && (enq_q == QW'(g));
    assign pop     = deq_req && (deq_q == QW'(g)) && (cnt_q != '0);
    assign set_bit = push ? ({{(SLOTS-1){1'b0}}, 1'b1} << enq_ptr) : '0;
    assign clr_bit = pop  ? ({{(SLOTS-1){1'b0}}, 1'b1} << head_q)  : '0;

    always_ff @(posedge clk) begin
      if (push && cnt_q != '0) nxt_q[tail_q] <= enq_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        tail_q <= '0;
        cnt_q  <= '0;
        mem_q  <= '0;
      end else begin
        if (push) tail_q <= enq_ptr;
        if (pop) head_q <= (cnt_q == CW'(1)) ? enq_ptr : nxt_q[head_q];
        else if (push && cnt_q == '0) head_q <= enq_ptr;
        cnt_q <= cnt_q + CW'(push) - CW'(pop);
        mem_q <= (mem_q | set_bit) & ~clr_bit;
      end
    end

    assign nonempty[g] = (cnt_q != '0);
    assign head_v[g]   = head_q;
    assign member_v[g] = mem_q;

    AST_Q_MEMBERS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      CW'($countones(mem_q)) == cnt_q); // R4
    AST_Q_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !mem_q[enq_ptr]); // R10
    AST_Q_EMPTY_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_req && deq_q == QW'(g) && cnt_q == '0 && !push) |=> (cnt_q == '0)); // R5
  end

  assign deq_hit = deq_req && nonempty[deq_q];
  assign deq_ptr = head_v[deq_q];
  assign enq_dup = member_v[enq_q][enq_ptr];
endmodule

// File: rtl/cbm_ctrl_mem.sv
module cbm_ctrl_mem
  import cbm_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned MC_W  = 3,
  parameter int unsigned VC_W  = 16,
  localparam int unsigned PW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PW-1:0]   load_ptr,
  input  logic [MC_W-1:0] load_mc,
  input  logic [1:0]      load_src,
  input  logic [VC_W-1:0] load_vc,
  input  logic            dec_en,
  input  logic [PW-1:0]   dec_ptr,
  input  logic [PW-1:0]   chk_ptr,
  output logic            chk_loaded,
  output logic [1:0]      out_src,
  output logic [VC_W-1:0] out_vc,
  output logic            out_last
);
  logic [MC_W-1:0] mc_q  [SLOTS];
  cell_src_e       src_q [SLOTS];
  logic [VC_W-1:0] vc_q  [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mc_q[i] <= '0;
    end else begin
      if (load_en) mc_q[load_ptr] <= load_mc;
      if (dec_en)  mc_q[dec_ptr]  <= MC_W'(mc_after_send(int'(mc_q[dec_ptr])));
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      src_q[load_ptr] <= cell_src_e'(load_src);
      vc_q[load_ptr]  <= load_vc;
    end
  end

  assign chk_loaded = (mc_q[chk_ptr] != '0);
  assign out_src    = src_q[dec_ptr];
  assign out_vc     = vc_q[dec_ptr];
  assign out_last   = (mc_q[dec_ptr] == MC_W'(1));

  AST_MC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (mc_q[dec_ptr] != '0)); // R6
  AST_LOAD_DEC_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && dec_en) |-> (load_ptr != dec_ptr)); // R6
  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (mc_q[load_ptr] == '0 && load_mc != '0)); // R9
endmodule

// File: rtl/cell_buf_mgr.sv
module cell_buf_mgr
  import cbm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 16,
  parameter int unsigned NUM_QUEUES = 4,
  parameter int unsigned MC_W       = 3,
  parameter int unsigned VC_W       = 16,
  localparam int unsigned PW     = $clog2(NUM_SLOTS),
  localparam int unsigned QW     = $clog2(NUM_QUEUES),
  localparam int unsigned CW     = $clog2(NUM_SLOTS + 1),
  localparam int unsigned BASE_W = $clog2(NUM_SLOTS * SLOT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  output logic              alloc_gnt,
  output logic [PW-1:0]     alloc_ptr,
  output logic              pool_exhausted,
  output logic [CW-1:0]     free_slots,
  input  logic              enq_valid,
  input  logic [PW-1:0]     enq_ptr,
  input  logic [QW-1:0]     enq_qid,
  input  logic [MC_W-1:0]   enq_mcast,
  input  logic [1:0]        enq_src,
  input  logic [VC_W-1:0]   enq_vc,
  output logic              enq_err,
  input  logic              deq_req,
  input  logic [QW-1:0]     deq_qid,
  output logic              deq_ack,
  output logic              deq_valid,
  output logic [PW-1:0]     deq_ptr,
  output logic [BASE_W-1:0] deq_base,
  output logic [1:0]        deq_src,
  output logic [VC_W-1:0]   deq_vc,
  output logic              deq_released
);
  // Internal events, named for the assertions.
  logic              grant_now, release_now, enq_bad, enq_ok, load_now;
  logic [PW-1:0]     fl_head, head_ptr;
  logic              deq_hit, enq_dup, slot_loaded, last_copy;
  logic [1:0]        rd_src;
  logic [VC_W-1:0]   rd_vc;
  logic [NUM_SLOTS-1:0] allocated_q;

  cbm_free_list #(.SLOTS(NUM_SLOTS)) u_free (
    .clk(clk), .rst_n(rst_n), .take(alloc_req), .give(release_now),
    .give_ptr(head_ptr), .take_ok(grant_now), .head_ptr(fl_head), .avail(free_slots));

  cbm_tx_queues #(.SLOTS(NUM_SLOTS), .QUEUES(NUM_QUEUES)) u_queues (
    .clk(clk), .rst_n(rst_n), .enq_do(enq_ok), .enq_q(enq_qid), .enq_ptr(enq_ptr),
    .deq_req(deq_req), .deq_q(deq_qid), .deq_hit(deq_hit), .deq_ptr(head_ptr),
    .enq_dup(enq_dup));

  cbm_ctrl_mem #(.SLOTS(NUM_SLOTS), .MC_W(MC_W), .VC_W(VC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_en(load_now), .load_ptr(enq_ptr),
    .load_mc(enq_mcast), .load_src(enq_src), .load_vc(enq_vc),
    .dec_en(deq_hit), .dec_ptr(head_ptr), .chk_ptr(enq_ptr),
    .chk_loaded(slot_loaded), .out_src(rd_src), .out_vc(rd_vc), .out_last(last_copy));

  assign release_now = deq_hit && last_copy;
  assign enq_bad = enq_valid && ((enq_mcast == '0) || !allocated_q[enq_ptr] || enq_dup ||
                                 (release_now && head_ptr == enq_ptr));
  assign enq_ok   = enq_valid && !enq_bad;
  assign load_now = enq_ok && !slot_loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allocated_q    <= '0;
      alloc_gnt      <= 1'b0;
      alloc_ptr      <= '0;
      pool_exhausted <= 1'b0;
      enq_err        <= 1'b0;
      deq_ack        <= 1'b0;
      deq_valid      <= 1'b0;
      deq_ptr        <= '0;
      deq_base       <= '0;
      deq_src        <= '0;
      deq_vc         <= '0;
      deq_released   <= 1'b0;
    end else begin
      if (grant_now)   allocated_q[fl_head]  <= 1'b1;
      if (release_now) allocated_q[head_ptr] <= 1'b0;
      alloc_gnt <= grant_now;
      if (grant_now) alloc_ptr <= fl_head;
      if (alloc_req && !grant_now) pool_exhausted <= 1'b1;
      enq_err      <= enq_bad;
      deq_ack      <= deq_req;
      deq_valid    <= deq_hit;
      deq_released <= release_now;
      if (deq_hit) begin
        deq_ptr  <= head_ptr;
        deq_base <= BASE_W'(slot_word_base(int'(head_ptr)));
        deq_src  <= rd_src;
        deq_vc   <= rd_vc;
      end
    end
  end

  AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_now |-> !allocated_q[fl_head]); // R8
  AST_POOL_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_slots) + 32'($countones(allocated_q))) == NUM_SLOTS); // R2
  AST_EXHAUST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pool_exhausted |=> pool_exhausted); // R3
  AST_RELEASE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |-> allocated_q[head_ptr]); // R6
  AST_ZERO_MC_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_mcast == '0) |=> enq_err); // R9
  AST_DEQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req |=> deq_ack); // R5
  AST_FREE_SLOT_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ok |-> allocated_q[enq_ptr]); // R10
endmodule

// File: tb/cell_buf_mgr_bench.sv
module cell_buf_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, enq_valid = 1'b0, deq_req = 1'b0;
  logic [2:0] enq_ptr = '0;
  logic [1:0] enq_qid = '0, deq_qid = '0, enq_src = '0;
  logic [2:0] enq_mcast = '0;
  logic [15:0] enq_vc = '0;
  logic alloc_gnt, pool_exhausted, enq_err, deq_ack, deq_valid, deq_released;
  logic [2:0] alloc_ptr, deq_ptr;
  logic [3:0] free_slots;
  logic [6:0] deq_base;
  logic [1:0] deq_src;
  logic [15:0] deq_vc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int fl[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_buf_mgr #(.NUM_SLOTS(NS), .NUM_QUEUES(NQ), .MC_W(3), .VC_W(16)) u_cell_buf_mgr (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_ptr(alloc_ptr), .pool_exhausted(pool_exhausted), .free_slots(free_slots),
    .enq_valid(enq_valid), .enq_ptr(enq_ptr), .enq_qid(enq_qid), .enq_mcast(enq_mcast),
    .enq_src(enq_src), .enq_vc(enq_vc), .enq_err(enq_err), .deq_req(deq_req),
    .deq_qid(deq_qid), .deq_ack(deq_ack), .deq_valid(deq_valid), .deq_ptr(deq_ptr),
    .deq_base(deq_base), .deq_src(deq_src), .deq_vc(deq_vc), .deq_released(deq_released));

  function automatic int vc_of(input int p);
    return 16'hA000 + p * 3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic alloc_op(output int g, output int p);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    g = int'(alloc_gnt);
    p = int'(alloc_ptr);
  endtask

  task automatic enq_op(input int p, input int q, input int mc, input int src, input int vc,
                        output int err);
    enq_valid = 1'b1; enq_ptr = 3'(p); enq_qid = 2'(q);
    enq_mcast = 3'(mc); enq_src = 2'(src); enq_vc = 16'(vc);
    @(negedge clk);
    enq_valid = 1'b0;
    err = int'(enq_err);
  endtask

  task automatic deq_op(input int q, output int v, output int p, output int rel);
    deq_req = 1'b1; deq_qid = 2'(q);
    @(negedge clk);
    deq_req = 1'b0;
    chk("R5 deq_ack", int'(deq_ack), 1);
    v = int'(deq_valid); p = int'(deq_ptr); rel = int'(deq_released);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int g, p, e, err, v, rel, a, last;
    for (int i = 0; i < NS; i++) fl.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 free_slots at reset", int'(free_slots), NS);
    chk("R1 no grant at reset", int'(alloc_gnt), 0);
    chk("R1 exhausted clear at reset", int'(pool_exhausted), 0);

    // R1/R2 ascending allocation sweep
    for (int i = 0; i < NS; i++) begin
      alloc_op(g, p);
      e = fl.pop_front();
      chk("R2 grant", g, 1);
      chk("R1 ascending ptr", p, i);
      chk("R1 model ptr", p, e);
      chk("R2 free count", int'(free_slots), NS - 1 - i);
    end

    // R3 empty pool
    alloc_op(g, p);
    chk("R3 no grant when empty", g, 0);
    chk("R3 exhausted set", int'(pool_exhausted), 1);
    chk("R3 free stays zero", int'(free_slots), 0);

    // R9 zero multicast, R5 empty dequeue shows nothing queued
    enq_op(0, 0, 0, 0, 0, err);
    chk("R9 zero mcast rejected", err, 1);
    deq_op(0, v, p, rel);
    chk("R9 R5 queue still empty", v, 0);

    // R4/R11 unicast sweep over all slots and origin codes
    for (int s = 0; s < NS; s++) begin
      enq_op(s, s % NQ, 1, s % 4, vc_of(s), err);
      chk("R4 enqueue accepted", err, 0);
    end
    enq_op(0, 0, 1, 0, 0, err);
    chk("R10 duplicate on same queue rejected", err, 1);

    for (int q = 0; q < NQ; q++) begin
      for (int k = 0; k < NS / NQ; k++) begin
        e = q + NQ * k;
        deq_op(q, v, p, rel);
        chk("R4 deq_valid", v, 1);
        chk("R4 fifo order", p, e);
        chk("R12 slot base", int'(deq_base), e * 14);
        chk("R11 origin code", int'(deq_src), e % 4);
        chk("R11 circuit index", int'(deq_vc), vc_of(e));
        chk("R6 unicast released", rel, 1);
        fl.push_front(e);
      end
      deq_op(q, v, p, rel);
      chk("R5 drained queue invalid", v, 0);
    end
    chk("R6 all slots free", int'(free_slots), NS);
    chk("R3 exhausted sticky", int'(pool_exhausted), 1);

    // R7 LIFO reuse
    alloc_op(g, a);
    chk("R7 last released first", a, fl.pop_front());

    // R6 multicast over three queues; later mcast values ignored
    enq_op(a, 0, 3, 2, 16'h1234, err); chk("R6 mc enq q0", err, 0);
    enq_op(a, 1, 5, 0, 0, err);        chk("R6 mc enq q1", err, 0);
    enq_op(a, 2, 1, 0, 0, err);        chk("R6 mc enq q2", err, 0);
    deq_op(0, v, p, rel);
    chk("R6 first copy keeps slot", rel, 0);
    chk("R11 mc origin", int'(deq_src), 2);
    chk("R6 free after first copy", int'(free_slots), NS - 1);
    deq_op(1, v, p, rel);
    chk("R6 second copy keeps slot", rel, 0);
    chk("R11 mc vc from first enqueue", int'(deq_vc), 16'h1234);
    deq_op(2, v, p, rel);
    chk("R6 last copy frees slot", rel, 1);
    chk("R6 ptr of last copy", p, a);
    chk("R6 free after last copy", int'(free_slots), NS);
    fl.push_front(a);

    // R10 freed slot may not be enqueued
    enq_op(a, 3, 1, 0, 0, err);
    chk("R10 free slot rejected", err, 1);
    deq_op(3, v, p, rel);
    chk("R10 queue unchanged", v, 0);

    // R8 same-cycle allocation and release
    alloc_op(g, a);
    chk("R7 reuse again", a, fl.pop_front());
    enq_op(a, 3, 1, 1, 7, err);
    chk("R8 setup enqueue", err, 0);
    alloc_req = 1'b1; deq_req = 1'b1; deq_qid = 2'd3;
    @(negedge clk);
    alloc_req = 1'b0; deq_req = 1'b0;
    e = fl.pop_front();
    chk("R8 grant with release", int'(alloc_gnt), 1);
    chk("R8 grant from old head", int'(alloc_ptr), e);
    chk("R8 release seen", int'(deq_released), 1);
    fl.push_front(a);
    chk("R8 free count unchanged", int'(free_slots), fl.size());
    alloc_op(g, p);
    chk("R8 released slot granted next", p, fl.pop_front());

    // R3 drain, fail, then release and recover
    last = p;
    while (fl.size() > 0) begin
      alloc_op(g, p);
      chk("R1 drain ptr", p, fl.pop_front());
      last = p;
    end
    alloc_op(g, p);
    chk("R3 empty again", g, 0);
    enq_op(last, 1, 1, 3, 5, err);
    chk("R3 enqueue last slot", err, 0);
    deq_op(1, v, p, rel);
    chk("R3 release after exhaustion", rel, 1);
    alloc_op(g, p);
    chk("R3 grant after release", g, 1);
    chk("R3 head intact", p, last);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule